// File: doc/BRIEF.md
# Segment Bank Mapping Unit

This block translates a 16-bit processor address into a 19-bit physical RAM address. The processor space is cut into four 16 KiB segments, selected by the top two address bits. The RAM is made of sixteen 32 KiB elements, and each element has a lower and an upper 16 KiB half. Each segment owns a small bank register that names the element it uses. The half is not stored in that register. It follows from the parity of the segment: even segments use the lower half and odd segments use the upper half.

A host port writes and reads the four bank registers. Only the two lowest bits of the register address choose the register. The translation is combinational from the current register contents. A register write is captured on the clock edge, so the new mapping applies from the cycle after the write. Reset loads a map that passes the first 64 KiB of RAM straight through.

Top module: `seg_bank_map`

## Requirements
- R1: While reset is asserted and immediately after it is released, the bank registers for segments 0..3 hold elements 0, 0, 1, 1. With that map, `phys_addr` equals `cpu_addr` zero-extended to 19 bits for every processor address.
- R2: `phys_addr` is {bank[s], s[0], cpu_addr[13:0]}, where s = cpu_addr[15:14]. The element number occupies bits 18:15, the half-select is bit 14, and the offset is bits 13:0.
- R3: Segments 0 and 2 always produce half-select 0, and segments 1 and 3 always produce half-select 1, whatever element is stored for them.
- R4: A write with `host_we` high updates only the register numbered by `host_addr[1:0]`. Bits 7:2 of `host_addr` have no effect on which register is written or read.
- R5: `host_rdata` shows the register numbered by `host_addr[1:0]` without a clock delay. Bits 3:0 carry the stored element and bits 7:4 read as zero. Only `host_wdata[3:0]` is stored.
- R6: A write changes the translation only from the clock cycle after the write. In the cycle the write is presented, `phys_addr` still uses the old element.
- R7: While `host_we` is low, no bank register changes, whatever `host_addr` and `host_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address to translate |
| phys_addr | output | 19 | Translated RAM address |
| host_we | input | 1 | Bank register write enable |
| host_addr | input | 8 | Register address; bits 1:0 select the bank |
| host_wdata | input | 8 | Write data; bits 3:0 give the element number |
| host_rdata | output | 8 | Selected bank register, zero-extended |

## Verification
After reset, probe addresses at both edges of all four segments confirm the straight-through map. A vector table then writes many element values, including values whose upper nibble is non-zero. It uses register addresses with junk in the high bits, and it probes addresses at segment edges. Each probe is compared with a model of the bank registers, which separates errors in the element field from errors in the half bit and the offset field. Two checks look at the timing of a write: one just before the write edge confirms the old mapping, and one after it confirms the new mapping. Directed steps confirm that writes with the enable low are ignored, that aliased register addresses do not disturb the other registers, and that a second reset restores the default map.

// File: rtl/seg_bank_map.sv
module seg_bank_map #(
  parameter int ELEM_W  = 4,
  parameter int OFS_W   = 14,
  parameter int SEG_W   = 2,
  parameter int HADDR_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEG_W+OFS_W-1:0]  cpu_addr,
  output logic [ELEM_W+OFS_W:0]   phys_addr,
  input  logic                    host_we,
  input  logic [HADDR_W-1:0]      host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata
);
  localparam int NSEG = 1 << SEG_W;

  logic [ELEM_W-1:0]      bank_q [NSEG];
  logic [NSEG*ELEM_W-1:0] bank_flat;
  logic [SEG_W-1:0]       wsel;
  logic [SEG_W-1:0]       seg;

  assign wsel = host_addr[SEG_W-1:0];
  assign seg  = cpu_addr[SEG_W+OFS_W-1:OFS_W];

  for (genvar s = 0; s < NSEG; s++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[s] <= ELEM_W'(s / 2);
      else if (host_we && wsel == SEG_W'(s))
        bank_q[s] <= host_wdata[ELEM_W-1:0];
    end
    assign bank_flat[s*ELEM_W +: ELEM_W] = bank_q[s];
  end

  assign phys_addr  = {bank_q[seg], cpu_addr[OFS_W], cpu_addr[OFS_W-1:0]};
  assign host_rdata = DATA_W'(bank_q[wsel]);

  // R1
  reset_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> phys_addr == (ELEM_W+OFS_W+1)'(cpu_addr));

  // R6
  write_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_we) && $past(wsel) == seg) |->
      phys_addr[ELEM_W+OFS_W:OFS_W+1] == $past(host_wdata[ELEM_W-1:0]));

  // R7
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> $stable(bank_flat));

  // R5
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_we) && $past(wsel) == wsel) |->
      host_rdata == DATA_W'($past(host_wdata[ELEM_W-1:0])));
endmodule

// File: tb/seg_bank_map_test.sv
module seg_bank_map_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [18:0] phys_addr;
  logic        host_we = 0;
  logic [7:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;

  int n_chk = 0, n_fail = 0;
  logic [3:0] mdl [4];

  always #4 clk = ~clk;

  seg_bank_map uut (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  // {host_addr, host_wdata, probe cpu_addr}
  localparam logic [31:0] VEC [10] = '{
    {8'h00, 8'h0A, 16'h1234}, {8'h01, 8'hF7, 16'h4ABC},
    {8'h42, 8'h3C, 16'h8001}, {8'hFF, 8'h0F, 16'hFFFF},
    {8'h05, 8'h09, 16'h7FFF}, {8'h80, 8'h00, 16'h0000},
    {8'h02, 8'h05, 16'hBFFF}, {8'h03, 8'h0E, 16'hC000},
    {8'hA1, 8'h02, 16'h4000}, {8'h10, 8'hF3, 16'h3FFF}};

  function automatic logic [18:0] exp_phys(input logic [15:0] a);
    return {mdl[a[15:14]], a[14], a[13:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    mdl[0] = 0; mdl[1] = 0; mdl[2] = 1; mdl[3] = 1;
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 4; s++) begin
      cpu_addr = {s[1:0], 14'h0000}; #1;
      chk(req, 32'(phys_addr), 32'(exp_phys(cpu_addr)));
      cpu_addr = {s[1:0], 14'h3FFF}; #1;
      chk(req, 32'(phys_addr), 32'(exp_phys(cpu_addr)));
      chk("R3", 32'(phys_addr[14]), 32'(s % 2));
      host_addr = {6'h2A, s[1:0]}; #1;
      chk("R5", 32'(host_rdata), 32'({4'h0, mdl[s]}));
    end
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    reset_model();
    #20;
    sweep("R1");
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    sweep("R1");

    foreach (VEC[i]) begin
      @(negedge clk);
      host_addr = VEC[i][31:24]; host_wdata = VEC[i][23:16];
      cpu_addr = {host_addr[1:0], VEC[i][13:0]};
      host_we = 1; #1;
      chk("R6", 32'(phys_addr), 32'(exp_phys(cpu_addr)));
      @(negedge clk);
      host_we = 0;
      mdl[VEC[i][25:24]] = VEC[i][19:16];
      #1;
      chk("R2", 32'(phys_addr), 32'(exp_phys(cpu_addr)));
      chk("R5", 32'(host_rdata), 32'({4'h0, VEC[i][19:16]}));
      cpu_addr = VEC[i][15:0]; #1;
      chk("R2", 32'(phys_addr), 32'(exp_phys(cpu_addr)));
    end
    sweep("R4");

    @(negedge clk);
    host_we = 0;
    for (int k = 0; k < 4; k++) begin
      host_addr = 8'(k); host_wdata = 8'hBB;
      @(negedge clk);
    end
    sweep("R7");

    @(negedge clk);
    host_addr = 8'hFD; host_wdata = 8'h06; host_we = 1;
    @(negedge clk);
    host_we = 0; mdl[1] = 4'h6;
    sweep("R4");

    @(negedge clk) rst_n = 0;
    reset_model();
    #1;
    sweep("R1");
    @(negedge clk) rst_n = 1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule